// File: doc/BRIEF.md
# Two-Master Address-Decoding Bus Interconnect

This block sits between two bus masters and six slave ports. Each master places a request with an address, a write flag and write data. The block decodes the top three address bits into a region, checks whether that master may use the region, arbitrates against the other master, and forwards the access to the chosen slave. The slave sees only the low address bits, so every slave's internal address space starts at zero.

A master keeps its request asserted until it sees its grant in the same cycle. A master that is not granted is stalled and simply holds its request. Two memory regions belong to one master each. Two memory regions, the shared-peripheral port and a general-purpose port are open to both masters. On every open target, master 0 wins a simultaneous request. Read data comes back one cycle after the grant.

The block keeps per-master read and write access counters. It also keeps a counter of cycles in which both masters competed for the shared-peripheral port.

Top module: `dual_master_bus`

## Requirements
- R1: Address bits [ADDR_W-1:ADDR_W-3] select the region, with this encoding: 0 = private memory of master 0 (slave 0), 1 = private memory of master 1 (slave 1), 2 = open memory A (slave 2), 3 = open memory B (slave 3), 4 = shared peripheral (slave 4), 5 = general port (slave 5). The granted slave receives address bits [ADDR_W-4:0] as its offset, together with the write flag and the write data.
- R2: When master 1 accesses region 0, or master 0 accesses region 1, the master gets `m_gnt` and `m_err` high in the same cycle. No slave request is raised, no memory is changed, and no read data is returned.
- R3: An access to region 6 or 7 gets the same error response as R2: `m_gnt` and `m_err` high in the same cycle, and no slave request.
- R4: A request to a free, permitted target is granted combinationally in the same cycle. `m_gnt` is never high without `m_req`.
- R5: For a granted read without error, `m_rvalid` is high for exactly the next cycle, and `m_rdata` then carries the slave's data.
- R6: When both masters request the same open target (regions 2 to 5) in one cycle, master 0 is granted and master 1 stalls. Master 1 is granted in the first cycle in which master 0 no longer requests that target.
- R7: `clash_cnt` increases by one in each cycle in which both masters request region 4 with no error.
- R8: `rd_cnt[m]` and `wr_cnt[m]` count master m's granted, error-free reads and writes. Error responses and stalled cycles leave them unchanged.
- R9: After reset all counters read zero and `m_gnt`, `m_err`, `m_rvalid` and `s_req` are low while the masters are idle.
- R10: Requests from the two masters to different permitted targets are both granted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| m_req | input | 2 | Request, one bit per master |
| m_we | input | 2 | Write flag per master (1 = write) |
| m_addr | input | 2 x ADDR_W | Address per master |
| m_wdata | input | 2 x DATA_W | Write data per master |
| m_gnt | output | 2 | Grant (access taken this cycle) |
| m_err | output | 2 | Error response for forbidden or unmapped region |
| m_rvalid | output | 2 | Read data valid, one cycle after grant |
| m_rdata | output | 2 x DATA_W | Read data per master |
| s_req | output | 6 | Access strobe per slave |
| s_we | output | 6 | Write flag per slave |
| s_addr | output | 6 x (ADDR_W-3) | Slave-local offset |
| s_wdata | output | 6 x DATA_W | Write data per slave |
| s_rdata | input | 6 x DATA_W | Slave read data, valid the cycle after a read strobe |
| rd_cnt | output | 2 x CNT_W | Granted read count per master |
| wr_cnt | output | 2 x CNT_W | Granted write count per master |
| clash_cnt | output | CNT_W | Count of cycles with both masters contending for region 4 |

## Verification
Most state in this block is visible at the ports at once. A wrong decode or a wrong priority shows in the same cycle as a misplaced `m_gnt` or `s_req`. A wrong pending-read register shows one cycle later as a missing or misrouted `m_rvalid`/`m_rdata`. A leaked write from a forbidden or contended access does not show right away. It shows when the affected location is read back in a later access. A counter fault shows as a count that differs from the bench's own tally at the next sample.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
   localparam int NUM_MST = 2;
   localparam int NUM_SLV = 6;
   localparam int REG_W   = 3;
   localparam int IDX_W   = $clog2(NUM_SLV);

   typedef enum logic [REG_W-1:0] {
      RG_PRIV0   = 3'd0,
      RG_PRIV1   = 3'd1,
      RG_OPEN_A  = 3'd2,
      RG_OPEN_B  = 3'd3,
      RG_SHARED  = 3'd4,
      RG_GENERAL = 3'd5,
      RG_HOLE6   = 3'd6,
      RG_HOLE7   = 3'd7
   } region_e;

   localparam int SHARED_SLV = 4;
endpackage

// File: rtl/mxb_decode.sv
module mxb_decode
   import mxb_pkg::*;
#(
   parameter int MST_ID = 0
)(
   input  logic [REG_W-1:0]   region,
   output logic [NUM_SLV-1:0] hit,
   output logic               bad
);
   if (MST_ID < 0 || MST_ID >= NUM_MST) begin : g_bad_id
      $error("mxb_decode: MST_ID out of range");
   end

   always_comb begin
      hit = '0;
      bad = 1'b0;
      case (region_e'(region))
         RG_PRIV0:   if (MST_ID == 0) hit[0] = 1'b1; else bad = 1'b1;
         RG_PRIV1:   if (MST_ID == 1) hit[1] = 1'b1; else bad = 1'b1;
         RG_OPEN_A:  hit[2] = 1'b1;
         RG_OPEN_B:  hit[3] = 1'b1;
         RG_SHARED:  hit[4] = 1'b1;
         RG_GENERAL: hit[5] = 1'b1;
         default:    bad = 1'b1;
      endcase
   end
endmodule

// File: rtl/mxb_arb.sv
module mxb_arb
   import mxb_pkg::*;
#(
   parameter bit BOTH = 1'b1
)(
   input  logic [NUM_MST-1:0] want,
   output logic [NUM_MST-1:0] gnt
);
   if (BOTH) begin : g_fixed_prio
      always_comb begin
         gnt = '0;
         if (want[0])      gnt[0] = 1'b1;
         else if (want[1]) gnt[1] = 1'b1;
      end
   end else begin : g_single_owner
      // decoder lets only the owning master reach a private slave
      assign gnt = want;
   end
endmodule

// File: rtl/mxb_stats.sv
module mxb_stats
   import mxb_pkg::*;
#(
   parameter int CNT_W = 16
)(
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [NUM_MST-1:0]              acc_rd,
   input  logic [NUM_MST-1:0]              acc_wr,
   input  logic                            clash,
   output logic [NUM_MST-1:0][CNT_W-1:0]   rd_cnt,
   output logic [NUM_MST-1:0][CNT_W-1:0]   wr_cnt,
   output logic [CNT_W-1:0]                clash_cnt
);
   if (CNT_W < 1) begin : g_bad_cnt
      $error("mxb_stats: CNT_W must be positive");
   end

   for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_cnt[m] <= '0;
            wr_cnt[m] <= '0;
         end else begin
            if (acc_rd[m]) rd_cnt[m] <= rd_cnt[m] + 1'b1;
            if (acc_wr[m]) wr_cnt[m] <= wr_cnt[m] + 1'b1;
         end
      end

      // R8
      rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_rd[m] |=> $stable(rd_cnt[m]));
      // R8
      wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !acc_wr[m] |=> $stable(wr_cnt[m]));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     clash_cnt <= '0;
      else if (clash) clash_cnt <= clash_cnt + 1'b1;
   end

   // R7
   clash_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clash |=> clash_cnt == $past(clash_cnt) + 1'b1);
endmodule

// File: rtl/dual_master_bus.sv
module dual_master_bus
   import mxb_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 32,
   parameter int CNT_W  = 16
)(
   input  logic                                          clk,
   input  logic                                          rst_n,
   input  logic [NUM_MST-1:0]                            m_req,
   input  logic [NUM_MST-1:0]                            m_we,
   input  logic [NUM_MST-1:0][ADDR_W-1:0]                m_addr,
   input  logic [NUM_MST-1:0][DATA_W-1:0]                m_wdata,
   output logic [NUM_MST-1:0]                            m_gnt,
   output logic [NUM_MST-1:0]                            m_err,
   output logic [NUM_MST-1:0]                            m_rvalid,
   output logic [NUM_MST-1:0][DATA_W-1:0]                m_rdata,
   output logic [NUM_SLV-1:0]                            s_req,
   output logic [NUM_SLV-1:0]                            s_we,
   output logic [NUM_SLV-1:0][ADDR_W-REG_W-1:0]          s_addr,
   output logic [NUM_SLV-1:0][DATA_W-1:0]                s_wdata,
   input  logic [NUM_SLV-1:0][DATA_W-1:0]                s_rdata,
   output logic [NUM_MST-1:0][CNT_W-1:0]                 rd_cnt,
   output logic [NUM_MST-1:0][CNT_W-1:0]                 wr_cnt,
   output logic [CNT_W-1:0]                              clash_cnt
);
   localparam int OFF_W = ADDR_W - REG_W;

   if (ADDR_W <= REG_W) begin : g_bad_addr
      $error("dual_master_bus: ADDR_W must exceed the region field");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("dual_master_bus: DATA_W must be positive");
   end
   if (NUM_MST != 2) begin : g_bad_mst
      $error("dual_master_bus: exactly two masters supported");
   end

   logic [NUM_MST-1:0][NUM_SLV-1:0] hit;
   logic [NUM_MST-1:0]              bad;
   logic [NUM_SLV-1:0][NUM_MST-1:0] want;
   logic [NUM_SLV-1:0][NUM_MST-1:0] sgnt;
   logic [NUM_MST-1:0]              taken;
   logic [NUM_MST-1:0]              rd_pend;
   logic [NUM_MST-1:0][IDX_W-1:0]   rd_src;

   // ---------------- per-master decode and return path ----------------
   for (genvar m = 0; m < NUM_MST; m++) begin : g_mst
      logic [NUM_SLV-1:0] col;
      logic [IDX_W-1:0]   idx;

      mxb_decode #(.MST_ID(m)) u_dec (
         .region (m_addr[m][ADDR_W-1 -: REG_W]),
         .hit    (hit[m]),
         .bad    (bad[m])
      );

      always_comb begin
         idx = '0;
         for (int s = 0; s < NUM_SLV; s++) begin
            col[s] = sgnt[s][m];
            if (sgnt[s][m]) idx = IDX_W'(s);
         end
      end

      assign taken[m] = |col;
      assign m_err[m] = m_req[m] & bad[m];
      assign m_gnt[m] = taken[m] | m_err[m];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rd_pend[m] <= 1'b0;
            rd_src[m]  <= '0;
         end else begin
            rd_pend[m] <= taken[m] & ~m_we[m];
            if (taken[m]) rd_src[m] <= idx;
         end
      end

      assign m_rvalid[m] = rd_pend[m];
      assign m_rdata[m]  = rd_pend[m] ? s_rdata[rd_src[m]] : '0;

      // R4
      gnt_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m_gnt[m] |-> m_req[m]);
      // R3
      err_no_slave_chk: assert property (@(posedge clk) disable iff (!rst_n)
         m_err[m] |-> !taken[m]);
      // R5
      rd_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (taken[m] && !m_we[m]) |=> m_rvalid[m]);
      // R5
      no_stray_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !(taken[m] && !m_we[m]) |=> !m_rvalid[m]);
   end

   // ---------------- per-slave arbitration and forwarding ----------------
   for (genvar s = 0; s < NUM_SLV; s++) begin : g_slv
      logic win;

      for (genvar m = 0; m < NUM_MST; m++) begin : g_want
         assign want[s][m] = m_req[m] & hit[m][s];
      end

      mxb_arb #(.BOTH(s >= 2)) u_arb (
         .want (want[s]),
         .gnt  (sgnt[s])
      );

      assign win        = sgnt[s][1];
      assign s_req[s]   = |sgnt[s];
      assign s_we[s]    = m_we[win];
      assign s_addr[s]  = m_addr[win][OFF_W-1:0];
      assign s_wdata[s] = m_wdata[win];

      if (s >= 2) begin : g_open_chk
         // R6
         prio_m0_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (want[s] == 2'b11) |-> (sgnt[s] == 2'b01));
      end
   end

   // R2
   priv_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sgnt[0][1] && !sgnt[1][0]);

   // ---------------- statistics ----------------
   mxb_stats #(.CNT_W(CNT_W)) u_stats (
      .clk       (clk),
      .rst_n     (rst_n),
      .acc_rd    (taken & ~m_we),
      .acc_wr    (taken & m_we),
      .clash     (&want[SHARED_SLV]),
      .rd_cnt    (rd_cnt),
      .wr_cnt    (wr_cnt),
      .clash_cnt (clash_cnt)
   );
endmodule

// File: tb/dual_master_bus_tb.sv
module dual_master_bus_tb;
   localparam int AW = 16;
   localparam int DW = 32;
   localparam int CW = 16;
   localparam int OW = AW - 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic [1:0]              m_req = '0, m_we = '0;
   logic [1:0][AW-1:0]      m_addr = '0;
   logic [1:0][DW-1:0]      m_wdata = '0;
   logic [1:0]              m_gnt, m_err, m_rvalid;
   logic [1:0][DW-1:0]      m_rdata;
   logic [5:0]              s_req, s_we;
   logic [5:0][OW-1:0]      s_addr;
   logic [5:0][DW-1:0]      s_wdata;
   logic [5:0][DW-1:0]      s_rdata;
   logic [1:0][CW-1:0]      rd_cnt, wr_cnt;
   logic [CW-1:0]           clash_cnt;

   dual_master_bus #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) u_dut (
      .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
      .m_wdata(m_wdata), .m_gnt(m_gnt), .m_err(m_err), .m_rvalid(m_rvalid),
      .m_rdata(m_rdata), .s_req(s_req), .s_we(s_we), .s_addr(s_addr),
      .s_wdata(s_wdata), .s_rdata(s_rdata), .rd_cnt(rd_cnt), .wr_cnt(wr_cnt),
      .clash_cnt(clash_cnt)
   );

   // slave models: 16-word memories, read data valid the cycle after the strobe
   logic [DW-1:0] mem [6][16];
   always @(posedge clk) begin
      for (int s = 0; s < 6; s++) begin
         if (s_req[s]) begin
            if (s_we[s]) mem[s][s_addr[s][3:0]] <= s_wdata[s];
            else         s_rdata[s] <= mem[s][s_addr[s][3:0]];
         end
      end
   end

   int checks = 0, errors = 0;
   int exp_rd [2] = '{0, 0};
   int exp_wr [2] = '{0, 0};
   int exp_clash = 0;
   bit done = 1'b0;

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic logic [AW-1:0] mk(input int rg, input int off);
      return {rg[2:0], off[OW-1:0]};
   endfunction

   task automatic drive(input int m, input bit we, input int rg, input int off,
                        input logic [DW-1:0] d);
      m_req[m]   = 1'b1;
      m_we[m]    = we;
      m_addr[m]  = mk(rg, off);
      m_wdata[m] = d;
   endtask

   task automatic idle();
      m_req = '0;
      m_we  = '0;
   endtask

   // single uncontended access; checks grant, slave side and read return
   task automatic single(input int m, input bit we, input int rg, input int off,
                         input logic [DW-1:0] d, input string req);
      @(negedge clk);
      drive(m, we, rg, off, d);
      #1;
      chk(m_gnt[m] && !m_err[m], req, "grant", {m_err[m], m_gnt[m]}, 2'b01);
      chk(s_req == (6'b1 << rg), req, "slave strobe", s_req, 6'b1 << rg);
      chk(s_addr[rg] == OW'(off), req, "slave offset", s_addr[rg], off);
      if (we) exp_wr[m]++; else exp_rd[m]++;
      @(negedge clk);
      idle();
      #1;
      if (!we) begin
         chk(m_rvalid[m] == 1'b1, "R5", "rvalid", m_rvalid[m], 1);
         chk(m_rdata[m] == d, "R5", "rdata", m_rdata[m], d);
      end else begin
         chk(m_rvalid == 2'b00, req, "no rvalid after write", m_rvalid, 0);
      end
   endtask

   task automatic t_reset();
      #1;
      chk(m_gnt == 0 && m_err == 0 && m_rvalid == 0 && s_req == 0, "R9",
          "outputs idle", {m_gnt, m_err, m_rvalid, s_req}, 0);
      chk(rd_cnt == 0 && wr_cnt == 0 && clash_cnt == 0, "R9", "counters",
          {rd_cnt, wr_cnt}, 0);
   endtask

   task automatic t_decode();
      single(0, 1'b1, 2, 5, 32'hA5A5_0001, "R1");
      single(0, 1'b0, 2, 5, 32'hA5A5_0001, "R1");
      single(0, 1'b1, 0, 9, 32'h0000_1111, "R1");
      single(0, 1'b0, 0, 9, 32'h0000_1111, "R1");
      single(1, 1'b1, 1, 3, 32'h2222_0000, "R1");
      single(1, 1'b0, 1, 3, 32'h2222_0000, "R1");
      single(1, 1'b1, 5, 15, 32'h5555_5555, "R4");
      single(1, 1'b0, 5, 15, 32'h5555_5555, "R4");
   endtask

   task automatic t_error(input int m, input int rg, input bit we, input string req);
      @(negedge clk);
      drive(m, we, rg, (rg == 0) ? 9 : 3, 32'hDEAD_BEEF);
      #1;
      chk(m_gnt[m] && m_err[m], req, "error response", {m_err[m], m_gnt[m]}, 2'b11);
      chk(s_req == 0, req, "no slave strobe", s_req, 0);
      @(negedge clk);
      idle();
      #1;
      chk(m_rvalid == 0, req, "no read data", m_rvalid, 0);
   endtask

   task automatic t_priv();
      t_error(1, 0, 1'b1, "R2");
      t_error(0, 1, 1'b1, "R2");
      // private memories unchanged by the forbidden writes
      single(0, 1'b0, 0, 9, 32'h0000_1111, "R2");
      single(1, 1'b0, 1, 3, 32'h2222_0000, "R2");
   endtask

   task automatic t_unmapped();
      t_error(0, 6, 1'b0, "R3");
      t_error(1, 7, 1'b1, "R3");
   endtask

   task automatic t_open_clash();
      @(negedge clk);
      drive(0, 1'b1, 3, 7, 32'h0000_00AA);
      drive(1, 1'b1, 3, 7, 32'h0000_00BB);
      #1;
      chk(m_gnt == 2'b01, "R6", "m0 wins open memory", m_gnt, 2'b01);
      chk(s_wdata[3] == 32'hAA, "R6", "m0 data forwarded", s_wdata[3], 32'hAA);
      exp_wr[0]++;
      @(negedge clk);
      m_req[0] = 1'b0;
      #1;
      chk(m_gnt == 2'b10, "R6", "stalled m1 granted", m_gnt, 2'b10);
      chk(s_wdata[3] == 32'hBB, "R6", "m1 data forwarded", s_wdata[3], 32'hBB);
      exp_wr[1]++;
      @(negedge clk);
      idle();
      single(0, 1'b0, 3, 7, 32'h0000_00BB, "R6");
   endtask

   task automatic t_shared();
      single(0, 1'b1, 4, 2, 32'h4444_0002, "R7");
      @(negedge clk);
      drive(0, 1'b0, 4, 2, '0);
      drive(1, 1'b0, 4, 2, '0);
      #1;
      chk(m_gnt == 2'b01, "R7", "shared port priority", m_gnt, 2'b01);
      exp_rd[0]++;
      exp_clash++;
      @(negedge clk);
      m_req[0] = 1'b0;
      #1;
      chk(m_gnt == 2'b10, "R7", "m1 after stall", m_gnt, 2'b10);
      chk(m_rvalid == 2'b01 && m_rdata[0] == 32'h4444_0002, "R5",
          "m0 shared read", m_rdata[0], 32'h4444_0002);
      chk(clash_cnt == CW'(exp_clash), "R7", "clash count", clash_cnt, exp_clash);
      exp_rd[1]++;
      @(negedge clk);
      idle();
      #1;
      chk(m_rvalid == 2'b10 && m_rdata[1] == 32'h4444_0002, "R5",
          "m1 shared read", m_rdata[1], 32'h4444_0002);
      chk(clash_cnt == CW'(exp_clash), "R7", "no clash when alone", clash_cnt, exp_clash);
   endtask

   task automatic t_parallel();
      @(negedge clk);
      drive(0, 1'b0, 2, 5, '0);
      drive(1, 1'b0, 5, 15, '0);
      #1;
      chk(m_gnt == 2'b11 && m_err == 0, "R10", "both granted", m_gnt, 2'b11);
      chk(s_req == 6'b100100, "R10", "two slave strobes", s_req, 6'b100100);
      exp_rd[0]++;
      exp_rd[1]++;
      @(negedge clk);
      idle();
      #1;
      chk(m_rdata[0] == 32'hA5A5_0001 && m_rdata[1] == 32'h5555_5555, "R10",
          "both read data", {m_rdata[1], m_rdata[0]}, {32'h5555_5555, 32'hA5A5_0001});
   endtask

   task automatic t_counts();
      @(negedge clk);
      #1;
      for (int m = 0; m < 2; m++) begin
         chk(rd_cnt[m] == CW'(exp_rd[m]), "R8", "read count", rd_cnt[m], exp_rd[m]);
         chk(wr_cnt[m] == CW'(exp_wr[m]), "R8", "write count", wr_cnt[m], exp_wr[m]);
      end
      chk(clash_cnt == CW'(exp_clash), "R7", "final clash count", clash_cnt, exp_clash);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_decode();
      t_priv();
      t_unmapped();
      t_open_clash();
      t_shared();
      t_parallel();
      t_counts();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule